// File: doc/BRIEF.md
# Multiplexed Host Port Cycle Decoder

This block is the host-facing front end of a parallel slave port. An external master runs its cycles at its own pace and uses it to reach a 32-bit internal memory bus. One shared bus carries both addresses and data. The block qualifies a strobe from chip select and two data strobes. At the start of each strobe it captures a two-bit access code, a read/write line and, in narrow mode, a halfword-select line. From these it drives either a word request on the internal side or an access to its own address or control register.

A width-select pin is latched while reset is held. Narrow mode uses a 16-bit host bus and joins two host cycles into one internal word. Wide mode moves a full 32-bit word per host cycle. A ready output inserts wait states while an internal transfer is outstanding. The control register holds an interrupt bit. The internal side raises that bit, the host clears it, and an active-low pin mirrors it.

The internal side is a request/acknowledge interface. `mem_req` stays high, with address, direction and write data held, until `mem_ack` is seen for one cycle. Read data is taken in the acknowledge cycle.

Top module: `hport_front`

## Requirements
- R1: While reset is held and after it is released, `h_ready` is 0, `h_int_n` is 1 and `mem_req` is 0.
- R2: A host cycle begins only when `h_cs_n` is 0 and exactly one of `h_ds1_n`/`h_ds2_n` is 0. A strobe with chip select high, or with both data strobes low, produces no ready, no request and no register change.
- R3: Access code encoding on `h_acc`: 00 selects the control register, 10 the address register, 01 data with auto-increment and 11 data without it. A read of the address register returns the last address written.
- R4: In narrow mode, halfword select 0 addresses bits 15:0 and 1 addresses bits 31:16. A data write issues one word {second, first} after the second halfword. A read returns the selected half in `h_dout[15:0]` with the upper bits 0.
- R5: In wide mode each host cycle moves a full 32-bit word, and the halfword-select input has no effect.
- R6: `wide_sel` is sampled only while reset is asserted (1 = wide, 0 = narrow). Control register bit 0 reports the latched mode.
- R7: A data read cycle (the first halfword in narrow mode, every cycle in wide mode) issues an internal read. `h_ready` stays 0 until its acknowledge, so a data read waits longer than a control read.
- R8: With code 01 the address advances by 4 after each acknowledged word. With code 11 it is left unchanged.
- R9: Write data is captured at the end of the strobe, and the word write is issued then, to the current address.
- R10: A one-cycle `irq_set` pulse sets control bit 1. A host control write with bit 1 = 1 clears it, and a write with bit 1 = 0 leaves it unchanged.
- R11: `h_int_n` is the inverse of control bit 1.
- R12: While `mem_req` is 1 without `mem_ack`, the request, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R13: `h_doe` is 1 during a read strobe and 0 during a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_sel | input | 1 | Width select, sampled during reset (1 = 32-bit host bus) |
| h_cs_n | input | 1 | Host chip select, active low |
| h_ds1_n | input | 1 | Host data strobe 1, active low |
| h_ds2_n | input | 1 | Host data strobe 2, active low |
| h_rnw | input | 1 | 1 = host reads, 0 = host writes |
| h_acc | input | 2 | Access code |
| h_hsel | input | 1 | Halfword select (narrow mode only) |
| h_din | input | 32 | Host bus, inbound |
| h_dout | output | 32 | Host bus, outbound |
| h_doe | output | 1 | Host bus output enable |
| h_ready | output | 1 | 1 = current host cycle may complete |
| h_int_n | output | 1 | Host interrupt, active low |
| irq_set | input | 1 | Internal-side interrupt request pulse |
| mem_req | output | 1 | Internal word request |
| mem_we | output | 1 | 1 = write request |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write word |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | 32 | Read word, valid with acknowledge |

## Verification
A wrong internal address appears on `mem_addr` at the next data access, and in the readback of the address register. A lost or duplicated auto-increment therefore shows within one host cycle of the word that caused it. A wrong halfword pairing or held first half shows as a mismatched `mem_wdata` in the very request the second halfword triggers. A stuck outstanding flag shows as `h_ready` never rising, which the bench's per-cycle timeout catches within sixty clocks. A wrong interrupt bit is visible on `h_int_n` one clock after the set pulse or the clearing write.

// File: rtl/hport_pkg.sv
package hport_pkg;

    // Host access codes; the encoding is decoded by the cycle engine.
    typedef enum logic [1:0] {
        ACC_CTRL     = 2'b00,
        ACC_DATA_INC = 2'b01,
        ACC_ADDR     = 2'b10,
        ACC_DATA_FIX = 2'b11
    } acc_e;

    // Control register bit positions seen by the host.
    localparam int unsigned CTRL_WIDE_BIT = 0;
    localparam int unsigned CTRL_IRQ_BIT  = 1;

    // Host pins that are not part of the data bus.
    localparam int unsigned CTL_PINS = 7;

endpackage

// File: rtl/hport_sync.sv
module hport_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [STAGES-1:0][W-1:0] chain_q;
    logic [STAGES-1:0][W-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{rst_val}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/hport_irq.sv
module hport_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_set,
    input  logic irq_clr,
    output logic irq_bit
);

    logic bit_d, bit_q;

    // Host clear wins over a coincident set.
    always_comb begin
        bit_d = bit_q;
        if (irq_set) begin
            bit_d = 1'b1;
        end
        if (irq_clr) begin
            bit_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= bit_d;
        end
    end

    assign irq_bit = bit_q;

    // R10: clearing write drops the bit next cycle
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !irq_bit);

    // R10: set pulse without a clear raises the bit next cycle
    a_r10_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set && !irq_clr) |=> irq_bit);

endmodule

// File: rtl/hport_cycle.sv
module hport_cycle
    import hport_pkg::*;
#(
    parameter int unsigned DW        = 32,
    parameter int unsigned ADDR_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide_sel,
    input  logic          s_cs_n,
    input  logic          s_ds1_n,
    input  logic          s_ds2_n,
    input  logic          s_rnw,
    input  logic [1:0]    s_acc,
    input  logic          s_hsel,
    input  logic [DW-1:0] s_data,
    input  logic          irq_bit,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          h_ready,
    output logic [DW-1:0] h_dout,
    output logic          h_doe,
    output logic          irq_clr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    localparam int unsigned HW = DW / 2;

    typedef struct packed {
        logic          wide;
        logic          strb;
        logic          cyc;
        logic          rnw;
        acc_e          acc;
        logic          hsel;
        logic          fetch;
        logic          pend;
        logic          pend_we;
        logic          pend_inc;
        logic [DW-1:0] addr;
        logic [DW-1:0] maddr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rword;
        logic [HW-1:0] wlo;
    } state_t;

    state_t q, d;

    logic          strobe;
    logic          start;
    logic          finish;
    logic          first_half;
    logic [DW-1:0] ctrl_word;
    logic [DW-1:0] src_word;

    always_comb begin
        d       = q;
        irq_clr = 1'b0;

        strobe     = !s_cs_n && (s_ds1_n != s_ds2_n);
        start      = strobe && !q.strb;
        finish     = !strobe && q.strb;
        first_half = q.wide || !q.hsel;
        d.strb     = strobe;

        // Acknowledge of the outstanding word
        if (q.pend && mem_ack) begin
            d.pend = 1'b0;
            if (!q.pend_we) begin
                d.rword = mem_rdata;
            end
            if (q.pend_inc) begin
                d.addr = q.addr + DW'(ADDR_STEP);
            end
        end

        // Deferred read fetch, once nothing is outstanding
        if (q.fetch && !q.pend) begin
            d.fetch    = 1'b0;
            d.pend     = 1'b1;
            d.pend_we  = 1'b0;
            d.pend_inc = (q.acc == ACC_DATA_INC);
            d.maddr    = q.addr;
        end

        // Strobe becomes active: capture the cycle controls
        if (start) begin
            d.cyc   = 1'b1;
            d.rnw   = s_rnw;
            d.acc   = acc_e'(s_acc);
            d.hsel  = q.wide ? 1'b0 : s_hsel;
            d.fetch = s_rnw && s_acc[0] && (q.wide || !s_hsel);
        end

        // Strobe released: writes take effect here
        if (finish && q.cyc) begin
            d.cyc = 1'b0;
            if (!q.rnw) begin
                case (q.acc)
                    ACC_CTRL: begin
                        if (first_half && s_data[CTRL_IRQ_BIT]) begin
                            irq_clr = 1'b1;
                        end
                    end
                    ACC_ADDR: begin
                        if (q.wide) begin
                            d.addr = s_data;
                        end else if (q.hsel) begin
                            d.addr[DW-1:HW] = s_data[HW-1:0];
                        end else begin
                            d.addr[HW-1:0] = s_data[HW-1:0];
                        end
                    end
                    default: begin
                        if (!q.wide && !q.hsel) begin
                            d.wlo = s_data[HW-1:0];
                        end else begin
                            d.pend     = 1'b1;
                            d.pend_we  = 1'b1;
                            d.pend_inc = (q.acc == ACC_DATA_INC);
                            d.maddr    = q.addr;
                            d.wdata    = q.wide ? s_data : {s_data[HW-1:0], q.wlo};
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.wide <= wide_sel;
        end else begin
            q <= d;
        end
    end

    // Host-visible read value
    always_comb begin
        ctrl_word                = '0;
        ctrl_word[CTRL_WIDE_BIT] = q.wide;
        ctrl_word[CTRL_IRQ_BIT]  = irq_bit;
        case (q.acc)
            ACC_CTRL: src_word = ctrl_word;
            ACC_ADDR: src_word = q.addr;
            default:  src_word = q.rword;
        endcase
        if (q.wide) begin
            h_dout = src_word;
        end else if (q.hsel) begin
            h_dout = {{HW{1'b0}}, src_word[DW-1:HW]};
        end else begin
            h_dout = {{HW{1'b0}}, src_word[HW-1:0]};
        end
    end

    assign h_ready   = q.cyc && !q.pend && !q.fetch;
    assign h_doe     = q.cyc && q.rnw;
    assign mem_req   = q.pend;
    assign mem_we    = q.pend_we;
    assign mem_addr  = q.maddr;
    assign mem_wdata = q.wdata;

    // R12: request fields hold until acknowledged
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R7: no completion permission while a word is outstanding
    a_r7_wait_pending: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !h_ready);

    // R6: latched width never changes outside reset
    a_r6_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(q.wide));

    // R9: a write request starts only as the strobe is released
    a_r9_write_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && mem_we) |-> ($past(q.strb) && !q.strb));

endmodule

// File: rtl/hport_front.sv
module hport_front
    import hport_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_STEP   = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_sel,
    input  logic              h_cs_n,
    input  logic              h_ds1_n,
    input  logic              h_ds2_n,
    input  logic              h_rnw,
    input  logic [1:0]        h_acc,
    input  logic              h_hsel,
    input  logic [DATA_W-1:0] h_din,
    output logic [DATA_W-1:0] h_dout,
    output logic              h_doe,
    output logic              h_ready,
    output logic              h_int_n,
    input  logic              irq_set,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int unsigned SW = CTL_PINS + DATA_W;

    logic [SW-1:0]     raw_pins;
    logic [SW-1:0]     sync_pins;
    logic [SW-1:0]     idle_pins;
    logic              s_cs_n, s_ds1_n, s_ds2_n, s_rnw, s_hsel;
    logic [1:0]        s_acc;
    logic [DATA_W-1:0] s_data;
    logic              irq_bit;
    logic              irq_clr;

    assign raw_pins  = {h_cs_n, h_ds1_n, h_ds2_n, h_rnw, h_acc, h_hsel, h_din};
    assign idle_pins = {3'b111, {(SW-3){1'b0}}};
    assign {s_cs_n, s_ds1_n, s_ds2_n, s_rnw, s_acc, s_hsel, s_data} = sync_pins;

    hport_sync #(
        .W      (SW),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (idle_pins),
        .d_in    (raw_pins),
        .d_out   (sync_pins)
    );

    hport_cycle #(
        .DW        (DATA_W),
        .ADDR_STEP (ADDR_STEP)
    ) u_cycle (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_sel  (wide_sel),
        .s_cs_n    (s_cs_n),
        .s_ds1_n   (s_ds1_n),
        .s_ds2_n   (s_ds2_n),
        .s_rnw     (s_rnw),
        .s_acc     (s_acc),
        .s_hsel    (s_hsel),
        .s_data    (s_data),
        .irq_bit   (irq_bit),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .h_ready   (h_ready),
        .h_dout    (h_dout),
        .h_doe     (h_doe),
        .irq_clr   (irq_clr),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    hport_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_set (irq_set),
        .irq_clr (irq_clr),
        .irq_bit (irq_bit)
    );

    assign h_int_n = ~irq_bit;

endmodule

// File: tb/hport_front_tb_top.sv
module hport_front_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_sel = 1'b0;
    logic        h_cs_n = 1'b1, h_ds1_n = 1'b1, h_ds2_n = 1'b1, h_rnw = 1'b1, h_hsel = 1'b0;
    logic [1:0]  h_acc = 2'b00;
    logic [31:0] h_din = '0;
    logic [31:0] h_dout;
    logic        h_doe, h_ready, h_int_n;
    logic        irq_set = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] exp_q[$];
    logic [31:0] mem_arr [16];
    int lat_cnt = 0;
    logic last_oe;

    always #5 clk = ~clk;

    hport_front dut_i (
        .clk(clk), .rst_n(rst_n), .wide_sel(wide_sel),
        .h_cs_n(h_cs_n), .h_ds1_n(h_ds1_n), .h_ds2_n(h_ds2_n), .h_rnw(h_rnw),
        .h_acc(h_acc), .h_hsel(h_hsel), .h_din(h_din), .h_dout(h_dout),
        .h_doe(h_doe), .h_ready(h_ready), .h_int_n(h_int_n), .irq_set(irq_set),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic void chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endfunction

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Memory model: fixed latency, single-cycle acknowledge
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (!rst_n) begin
            lat_cnt <= 0;
        end else if (mem_req && !mem_ack) begin
            if (lat_cnt == 3) begin
                lat_cnt <= 0;
                mem_ack <= 1'b1;
                if (mem_we) mem_arr[mem_addr[5:2]] <= mem_wdata;
                else        mem_rdata <= mem_arr[mem_addr[5:2]];
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // Scoreboard monitor: writes seen on the internal side (R9, R12)
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack && mem_we) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected write", mem_addr, 32'hxxxx_xxxx);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                chk("R9 write address", mem_addr, e[63:32]);
                chk("R12 write data", mem_wdata, e[31:0]);
            end
        end
    end

    task automatic do_reset(input logic wide);
        @(negedge clk);
        rst_n = 1'b0; wide_sel = wide;
        h_cs_n = 1'b1; h_ds1_n = 1'b1; h_ds2_n = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_cycle(input logic [1:0] acc, input logic rnw, input logic hs,
                              input logic [31:0] wd, output logic [31:0] rd, output int waits);
        @(negedge clk);
        h_acc = acc; h_rnw = rnw; h_hsel = hs; h_din = wd; h_cs_n = 1'b0;
        repeat (2) @(negedge clk);
        h_ds1_n = 1'b0;
        waits = 0;
        while (!h_ready && waits < 60) begin
            @(negedge clk);
            waits++;
        end
        if (!h_ready) chk("R7 ready timeout", {31'b0, h_ready}, 32'h1);
        rd = h_dout;
        last_oe = h_doe;
        repeat (2) @(negedge clk);
        h_ds1_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic hwrite(input logic [1:0] acc, input logic hs, input logic [31:0] wd);
        logic [31:0] rd;
        int w;
        host_cycle(acc, 1'b0, hs, wd, rd, w);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog expired", 32'h0, 32'h1);
        report();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int w_ctrl, w_data, w;
        int bad_seen;

        do_reset(1'b0);
        // R1 reset state
        chk("R1 ready after reset", {31'b0, h_ready}, 32'h0);
        chk("R1 int pin after reset", {31'b0, h_int_n}, 32'h1);
        chk("R1 req after reset", {31'b0, mem_req}, 32'h0);

        // R6 narrow mode reported in control bit 0
        host_cycle(2'b00, 1'b1, 1'b0, '0, rd, w_ctrl);
        chk("R6 narrow control read", rd, 32'h0);

        // R3 / R4 address register halves
        hwrite(2'b10, 1'b0, 32'h0000_0010);
        hwrite(2'b10, 1'b1, 32'h0000_0000);
        host_cycle(2'b10, 1'b1, 1'b0, '0, rd, w);
        chk("R3 address low half", rd, 32'h0000_0010);
        host_cycle(2'b10, 1'b1, 1'b1, '0, rd, w);
        chk("R4 address high half", rd, 32'h0);

        // R4 / R9 halfword pair writes with auto-increment
        exp_q.push_back({32'h10, 32'hDEAD_BEEF});
        hwrite(2'b01, 1'b0, 32'h0000_BEEF);
        chk("R13 oe low on write", {31'b0, last_oe}, 32'h0);
        hwrite(2'b01, 1'b1, 32'h0000_DEAD);
        exp_q.push_back({32'h14, 32'h1234_5678});
        hwrite(2'b01, 1'b0, 32'h0000_5678);
        hwrite(2'b01, 1'b1, 32'h0000_1234);
        host_cycle(2'b10, 1'b1, 1'b0, '0, rd, w);
        chk("R8 address after two incrementing writes", rd, 32'h18);

        // R7 fixed-address data reads
        hwrite(2'b10, 1'b0, 32'h10);
        hwrite(2'b10, 1'b1, 32'h0);
        host_cycle(2'b11, 1'b1, 1'b0, '0, rd, w_data);
        chk("R7 fixed read low half", rd, 32'h0000_BEEF);
        chk("R13 oe high on read", {31'b0, last_oe}, 32'h1);
        chk("R7 data read waits longer", {31'b0, (w_data > w_ctrl)}, 32'h1);
        host_cycle(2'b11, 1'b1, 1'b1, '0, rd, w);
        chk("R4 fixed read high half", rd, 32'h0000_DEAD);
        host_cycle(2'b10, 1'b1, 1'b0, '0, rd, w);
        chk("R8 fixed read keeps address", rd, 32'h10);

        // R8 incrementing reads
        host_cycle(2'b01, 1'b1, 1'b0, '0, rd, w);
        chk("R8 inc read word0 low", rd, 32'h0000_BEEF);
        host_cycle(2'b01, 1'b1, 1'b1, '0, rd, w);
        chk("R8 inc read word0 high", rd, 32'h0000_DEAD);
        host_cycle(2'b01, 1'b1, 1'b0, '0, rd, w);
        chk("R8 inc read word1 low", rd, 32'h0000_5678);
        host_cycle(2'b10, 1'b1, 1'b0, '0, rd, w);
        chk("R8 address after inc reads", rd, 32'h18);

        // R2 unqualified strobes: chip select high, then both strobes low
        @(negedge clk);
        h_acc = 2'b01; h_rnw = 1'b1; h_hsel = 1'b0; h_cs_n = 1'b1; h_ds1_n = 1'b0;
        bad_seen = 0;
        repeat (20) begin @(negedge clk); if (h_ready || mem_req) bad_seen++; end
        h_ds1_n = 1'b1;
        repeat (6) @(negedge clk);
        h_cs_n = 1'b0; h_ds1_n = 1'b0; h_ds2_n = 1'b0;
        repeat (20) begin @(negedge clk); if (h_ready || mem_req) bad_seen++; end
        h_ds1_n = 1'b1; h_ds2_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 no response to unqualified strobe", bad_seen, 0);
        host_cycle(2'b10, 1'b1, 1'b0, '0, rd, w);
        chk("R2 address untouched", rd, 32'h18);

        // R10 / R11 interrupt bit
        @(negedge clk); irq_set = 1'b1;
        @(negedge clk); irq_set = 1'b0;
        chk("R11 pin low after set", {31'b0, h_int_n}, 32'h0);
        host_cycle(2'b00, 1'b1, 1'b0, '0, rd, w);
        chk("R10 control shows bit", rd, 32'h2);
        hwrite(2'b00, 1'b0, 32'h0);
        chk("R10 write of 0 keeps bit", {31'b0, h_int_n}, 32'h0);
        hwrite(2'b00, 1'b0, 32'h2);
        chk("R10 write of 1 clears bit", {31'b0, h_int_n}, 32'h1);

        // Wide mode
        do_reset(1'b1);
        wide_sel = 1'b0;
        host_cycle(2'b00, 1'b1, 1'b0, '0, rd, w);
        chk("R6 wide mode latched at reset", rd, 32'h1);
        hwrite(2'b10, 1'b1, 32'h0000_0020);
        host_cycle(2'b10, 1'b1, 1'b1, '0, rd, w);
        chk("R5 wide address full word", rd, 32'h20);
        exp_q.push_back({32'h20, 32'hCAFE_F00D});
        hwrite(2'b11, 1'b1, 32'hCAFE_F00D);
        host_cycle(2'b11, 1'b1, 1'b1, '0, rd, w);
        chk("R5 wide read full word", rd, 32'hCAFE_F00D);

        repeat (10) @(negedge clk);
        chk("R9 all expected writes seen", exp_q.size(), 0);
        report();
        $finish;
    end

endmodule